// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block gathers interrupt requests from a set of source lines and turns them into two processor request outputs, a normal one and a fast one. Each line is set up on its own to act on a level (active high or active low) or on an edge (rising or falling). Level lines show their current state. Edge lines hold the event until software clears it by writing a one to that line's bit in the raw status register. An enable mask gates each line. A per-line route bit sends an enabled, pending line to either the normal or the fast output. A combinational encoder reports the lowest-numbered enabled pending line, so the service routine can work through pending lines from index 0 upward.

The top level holds two controller units, a primary and a secondary. The secondary's normal request output drives line 0 of the primary, through the primary's synchronizer. This lets one primary line stand for a whole group of secondary lines. Software configures primary line 0 as active-high level. Both units share one synchronous register bus: address bit 5 selects the unit, and address bits 4:0 give a word-aligned byte offset inside the unit. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `irqc_cascade`

## Requirements
- R1: After reset the enable (0x00), polarity (0x0C), type (0x10) and fast-route (0x14) registers of both units read as zero, so every line is disabled, active-low and level. With all inputs low, raw status (0x04) reads all ones. Masked status (0x08), both request outputs of both units and both valid flags read as zero.
- R2: The enable, polarity, type and fast-route registers hold a written word and read it back. A write to masked status (0x08) changes no register. Masked status always reads as raw status AND enable.
- R3: A line whose type bit is 0 is level-sensitive. Its raw bit equals the synchronized input when its polarity bit is 1 and the inverted input when its polarity bit is 0. It follows the input two clock edges after the input changes. Writes to raw status do not affect it.
- R4: A line whose type bit is 1 is edge-triggered. A polarity of 1 catches rising edges and 0 catches falling edges. The raw bit is set by the third clock edge after the input change and then stays set, even after the input returns, until it is acknowledged.
- R5: Writing raw status (0x04) clears the latched edge of each line whose data bit is 1, at that clock edge. Data bits of 0 leave their lines unchanged.
- R6: When a new edge on a line is detected in the same cycle that an acknowledge for that line is written, the raw bit stays set.
- R7: The normal request output is the OR of the masked status bits whose fast-route bit is 0. The fast request output is the OR of the masked status bits whose fast-route bit is 1.
- R8: Each unit outputs a valid flag that is 1 exactly when masked status is nonzero, together with the index of the lowest set masked status bit.
- R9: The secondary unit's normal request drives primary line 0. With primary line 0 set as enabled, active-high and level, a pending enabled normal-routed secondary line shows up as primary raw bit 0 and on the primary's normal or fast output. Clearing the secondary line removes it again.
- R10: Changing a line from edge to level type discards its latched edge. Switching it back to edge type does not bring the old event back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both units |
| rst_n | input | 1 | Asynchronous active-low reset |
| prim_src_i | input | NL-1 | Primary source lines 1 to NL-1 (bit i is line i) |
| sec_src_i | input | NL | Secondary source lines 0 to NL-1 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Bit 5 selects the unit (0 primary, 1 secondary); bits 4:0 are a word-aligned byte offset |
| wdata_i | input | NL | Register write data |
| rdata_o | output | NL | Read data of the addressed register |
| irq_o | output | 1 | Primary normal request |
| fiq_o | output | 1 | Primary fast request |
| sec_irq_o | output | 1 | Secondary normal request (also feeds primary line 0) |
| sec_fiq_o | output | 1 | Secondary fast request |
| prim_idx_o | output | log2(NL) | Lowest pending enabled primary line |
| prim_valid_o | output | 1 | Primary masked status is nonzero |
| sec_idx_o | output | log2(NL) | Lowest pending enabled secondary line |
| sec_valid_o | output | 1 | Secondary masked status is nonzero |

## Verification
The assertions assume that the write strobe, address and data are stable around each rising edge. They also assume that the source lines are driven from the same clock domain, or that their glitches are absorbed by the synchronizer. The stimulus changes every input at the falling edge and holds each source level for several cycles. It waits long enough for the two synchronizer stages, plus the cascade hop, to settle before sampling. The one exception is the same-cycle acknowledge test, which places the write exactly on the edge where the detector fires. It does this by counting falling edges from the moment the input changes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // byte offset width inside one unit
    localparam int REG_OFS_W = 5;

    // word index (offset bits 4:2) of each register
    typedef enum logic [2:0] {
        RG_ENABLE = 3'd0,
        RG_RAW    = 3'd1,
        RG_MASKED = 3'd2,
        RG_POLAR  = 3'd3,
        RG_KIND   = 3'd4,
        RG_FAST   = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
    parameter  int W  = 32,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          valid_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
        valid_o = |vec_i;
    end
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
#(
    parameter  int NL = 32,
    localparam int IW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NL-1:0]        src_i,
    input  logic                 wr_en_i,
    input  logic [REG_OFS_W-1:0] addr_i,
    input  logic [NL-1:0]        wdata_i,
    output logic [NL-1:0]        rdata_o,
    output logic                 irq_o,
    output logic                 fiq_o,
    output logic [IW-1:0]        idx_o,
    output logic                 idx_valid_o
);
    localparam logic [NL-1:0] ONE = NL'(1);

    typedef struct packed {
        logic [NL-1:0] en;
        logic [NL-1:0] pol;
        logic [NL-1:0] kind;
        logic [NL-1:0] fast;
        logic [NL-1:0] latch;
        logic [NL-1:0] prev;
    } unit_st_t;

    unit_st_t      st_d, st_q;
    logic [NL-1:0] sync_w;
    logic [2:0]    wsel;
    logic          wr_ok;
    logic [NL-1:0] lvl_raw, det, ack, raw, masked;

    irqc_sync #(.W(NL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (sync_w)
    );

    always_comb begin
        wr_ok   = wr_en_i && (addr_i[1:0] == 2'b00);
        wsel    = addr_i[4:2];
        lvl_raw = ~(sync_w ^ st_q.pol);
        det     = (st_q.pol & sync_w & ~st_q.prev)
                | (~st_q.pol & ~sync_w & st_q.prev);
        ack     = (wr_ok && wsel == RG_RAW) ? wdata_i : '0;
        raw     = (st_q.kind & st_q.latch) | (~st_q.kind & lvl_raw);
        masked  = raw & st_q.en;

        st_d       = st_q;
        st_d.prev  = sync_w;
        st_d.latch = st_q.kind & ((st_q.latch & ~ack) | det);
        if (wr_ok) begin
            case (wsel)
                RG_ENABLE: st_d.en   = wdata_i;
                RG_POLAR:  st_d.pol  = wdata_i;
                RG_KIND:   st_d.kind = wdata_i;
                RG_FAST:   st_d.fast = wdata_i;
                default:   ;
            endcase
        end

        case (wsel)
            RG_ENABLE: rdata_o = st_q.en;
            RG_RAW:    rdata_o = raw;
            RG_MASKED: rdata_o = masked;
            RG_POLAR:  rdata_o = st_q.pol;
            RG_KIND:   rdata_o = st_q.kind;
            RG_FAST:   rdata_o = st_q.fast;
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = |(masked & ~st_q.fast);
    assign fiq_o = |(masked & st_q.fast);

    irqc_lowest #(.W(NL)) u_low (
        .vec_i   (masked),
        .idx_o   (idx_o),
        .valid_o (idx_valid_o)
    );

    // enable register changes only through its own write
    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && wsel == RG_ENABLE) |=> $stable(st_q.en));

    // a latched edge falls only by acknowledge or type change
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.latch) & ~st_q.latch & ~$past(ack)
                   & $past(st_q.kind)) == '0));

    // acknowledged bits are clear unless a new edge arrived
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wsel == RG_RAW) |=>
        ((st_q.latch & $past(wdata_i) & ~$past(det)) == '0));

    // no request without a masked pending line
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (masked == '0) |-> (!irq_o && !fiq_o));

    // reported index is set and nothing below it is
    p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid_o |-> (masked[idx_o] && ((masked & ((ONE << idx_o) - ONE)) == '0)));
endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade
    import irqc_pkg::*;
#(
    parameter  int NL = 32,
    localparam int IW = (NL > 1) ? $clog2(NL) : 1,
    localparam int AW = REG_OFS_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:1] prim_src_i,
    input  logic [NL-1:0] sec_src_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NL-1:0] wdata_i,
    output logic [NL-1:0] rdata_o,
    output logic          irq_o,
    output logic          fiq_o,
    output logic          sec_irq_o,
    output logic          sec_fiq_o,
    output logic [IW-1:0] prim_idx_o,
    output logic          prim_valid_o,
    output logic [IW-1:0] sec_idx_o,
    output logic          sec_valid_o
);
    logic          sel_sec;
    logic          sec_irq_w;
    logic [NL-1:0] prim_lines;
    logic [NL-1:0] prim_rd, sec_rd;

    assign sel_sec    = addr_i[AW-1];
    assign prim_lines = {prim_src_i, sec_irq_w};

    irqc_unit #(.NL(NL)) u_sec (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (sec_src_i),
        .wr_en_i     (wr_en_i && sel_sec),
        .addr_i      (addr_i[REG_OFS_W-1:0]),
        .wdata_i     (wdata_i),
        .rdata_o     (sec_rd),
        .irq_o       (sec_irq_w),
        .fiq_o       (sec_fiq_o),
        .idx_o       (sec_idx_o),
        .idx_valid_o (sec_valid_o)
    );

    irqc_unit #(.NL(NL)) u_prim (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (prim_lines),
        .wr_en_i     (wr_en_i && !sel_sec),
        .addr_i      (addr_i[REG_OFS_W-1:0]),
        .wdata_i     (wdata_i),
        .rdata_o     (prim_rd),
        .irq_o       (irq_o),
        .fiq_o       (fiq_o),
        .idx_o       (prim_idx_o),
        .idx_valid_o (prim_valid_o)
    );

    assign sec_irq_o = sec_irq_w;
    assign rdata_o   = sel_sec ? sec_rd : prim_rd;

    // a request at either primary output needs a valid pending index
    p_prim_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> prim_valid_o);
endmodule

// File: tb/irqc_cascade_test.sv
module irqc_cascade_test;
    localparam int NL = 32;
    localparam logic [5:0] O_EN = 6'h00, O_RAW = 6'h04, O_MSK = 6'h08,
                           O_POL = 6'h0C, O_TYP = 6'h10, O_FST = 6'h14,
                           SEC = 6'h20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:1] prim_src;
    logic [NL-1:0] sec_src;
    logic          we;
    logic [5:0]    addr;
    logic [NL-1:0] wdata, rdata;
    logic          irq, fiq, sec_irq, sec_fiq, prim_valid, sec_valid;
    logic [4:0]    prim_idx, sec_idx;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    irqc_cascade #(.NL(NL)) uut (
        .clk(clk), .rst_n(rst_n), .prim_src_i(prim_src), .sec_src_i(sec_src),
        .wr_en_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq), .sec_irq_o(sec_irq), .sec_fiq_o(sec_fiq),
        .prim_idx_o(prim_idx), .prim_valid_o(prim_valid),
        .sec_idx_o(sec_idx), .sec_valid_o(sec_valid)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=%h exp=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, pol, m, f, s, exp_m;
        rst_n = 1'b0; prim_src = '0; sec_src = '0; we = 1'b0; addr = '0; wdata = '0;
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R1 reset state
        foreach (m[b]) ;
        for (int u = 0; u < 2; u++) begin
            logic [5:0] base = (u == 1) ? SEC : 6'h00;
            rd(base | O_EN,  v); check("R1 enable",  v, 0);
            rd(base | O_POL, v); check("R1 polarity", v, 0);
            rd(base | O_TYP, v); check("R1 type",    v, 0);
            rd(base | O_FST, v); check("R1 fast",    v, 0);
            rd(base | O_RAW, v); check("R1 raw",     v, 32'hFFFF_FFFF);
            rd(base | O_MSK, v); check("R1 masked",  v, 0);
        end
        check("R1 outputs", {irq, fiq, sec_irq, sec_fiq, prim_valid, sec_valid}, 0);

        // R2 register readback and masked-status write ignored
        for (int u = 0; u < 2; u++) begin
            logic [5:0] base = (u == 1) ? SEC : 6'h00;
            logic [5:0] offs [4] = '{O_EN, O_POL, O_TYP, O_FST};
            for (int k = 0; k < 4; k++) begin
                logic [31:0] pat = 32'hA5C3_0F96 ^ (32'h1357_9BDF * (k + 1 + u * 4));
                wr(base | offs[k], pat);
                rd(base | offs[k], v); check("R2 readback", v, pat);
            end
            wr(base | O_POL, 0); wr(base | O_TYP, 0); wr(base | O_FST, 0);
            wr(base | O_EN, 32'h3C3C_5AA5);
            idle(3);
            wr(base | O_MSK, 32'hFFFF_FFFF);
            rd(base | O_EN,  v); check("R2 masked write ignored", v, 32'h3C3C_5AA5);
            rd(base | O_MSK, v); check("R2 masked=raw&en", v, 32'h3C3C_5AA5);
            wr(base | O_EN, 0);
        end

        // R3 level sweep on secondary, each line and both polarities
        for (int i = 0; i < NL; i++) begin
            for (int p = 0; p < 2; p++) begin
                pol = (p == 1) ? (32'd1 << i) : 32'd0;
                wr(SEC | O_POL, pol);
                sec_src = '0; idle(4);
                rd(SEC | O_RAW, v); check("R3 level idle", v, ~(32'd0 ^ pol));
                sec_src = 32'd1 << i; idle(4);
                rd(SEC | O_RAW, v); check("R3 level active", v, ~(sec_src ^ pol));
                wr(SEC | O_RAW, 32'hFFFF_FFFF);
                rd(SEC | O_RAW, v); check("R3 ack write ignored", v, ~(sec_src ^ pol));
            end
        end
        sec_src = '0;

        // R4 and R5 edge sweep, rising then falling
        for (int p = 1; p >= 0; p--) begin
            wr(SEC | O_TYP, 0);
            pol = (p == 1) ? 32'hFFFF_FFFF : 32'h0;
            wr(SEC | O_POL, pol);
            sec_src = (p == 1) ? 32'h0 : 32'hFFFF_FFFF;
            idle(4);
            wr(SEC | O_TYP, 32'hFFFF_FFFF);
            for (int i = 0; i < NL; i++) begin
                sec_src[i] = ~sec_src[i]; idle(5);
                rd(SEC | O_RAW, v); check("R4 edge latched", v, 32'd1 << i);
                sec_src[i] = ~sec_src[i]; idle(5);
                rd(SEC | O_RAW, v); check("R4 edge held", v, 32'd1 << i);
                wr(SEC | O_RAW, 0);
                rd(SEC | O_RAW, v); check("R5 zero write", v, 32'd1 << i);
                wr(SEC | O_RAW, ~(32'd1 << i));
                rd(SEC | O_RAW, v); check("R5 other bits", v, 32'd1 << i);
                wr(SEC | O_RAW, 32'd1 << i);
                rd(SEC | O_RAW, v); check("R5 ack clears", v, 0);
            end
        end
        // now: polarity all 0 (falling), type edge, inputs high
        wr(SEC | O_TYP, 0);
        wr(SEC | O_POL, 32'hFFFF_FFFF);
        sec_src = '0; idle(4);
        wr(SEC | O_TYP, 32'hFFFF_FFFF);

        // R6 acknowledge in the same cycle as a fresh edge
        sec_src[5] = 1'b1; idle(5); sec_src[5] = 1'b0; idle(5);
        rd(SEC | O_RAW, v); check("R6 pre latched", v, 32'd1 << 5);
        @(negedge clk); sec_src[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); we = 1'b1; addr = SEC | O_RAW; wdata = 32'd1 << 5;
        @(negedge clk); we = 1'b0;
        rd(SEC | O_RAW, v); check("R6 edge wins", v, 32'd1 << 5);
        wr(SEC | O_RAW, 32'd1 << 5);
        rd(SEC | O_RAW, v); check("R6 later ack clears", v, 0);

        // R10 type change drops a latched edge
        sec_src[5] = 1'b0; idle(4);
        sec_src[5] = 1'b1; idle(5);
        rd(SEC | O_RAW, v); check("R10 latched", v, 32'd1 << 5);
        sec_src[5] = 1'b0; idle(4);
        wr(SEC | O_TYP, 0);
        rd(SEC | O_RAW, v); check("R10 level view", v, 0);
        wr(SEC | O_TYP, 32'hFFFF_FFFF);
        rd(SEC | O_RAW, v); check("R10 not restored", v, 0);
        wr(SEC | O_TYP, 0);

        // R7 and R8 pattern sweep on secondary (active-high level lines)
        for (int k = 0; k < 48; k++) begin
            s = (k % 8 == 0) ? 32'h0 : (32'h9E37_79B9 * k) ^ (32'd1 << (k % 32));
            m = (32'h7F4A_7C15 * (k + 3)) | ((k % 5 == 0) ? 32'hFFFF_FFFF : 32'h0);
            f = 32'h85EB_CA6B * (k + 7);
            wr(SEC | O_EN, m);
            wr(SEC | O_FST, f);
            sec_src = s; idle(4);
            exp_m = s & m;
            rd(SEC | O_MSK, v); check("R2 masked sweep", v, exp_m);
            check("R7 normal", sec_irq, |(exp_m & ~f));
            check("R7 fast",   sec_fiq, |(exp_m & f));
            check("R8 valid",  sec_valid, exp_m != 0);
            if (exp_m != 0) check("R8 index", sec_idx, lowest(exp_m));
        end
        sec_src = '0;
        wr(SEC | O_FST, 0);

        // R9 cascade into primary line 0
        wr(SEC | O_EN, 32'd1 << 7);
        wr(O_POL, 32'h1); wr(O_EN, 32'h1);
        sec_src = 32'd1 << 7; idle(7);
        check("R9 sec request", sec_irq, 1);
        rd(O_RAW, v); check("R9 primary raw", v, 32'hFFFF_FFFF);
        rd(O_MSK, v); check("R9 primary masked", v, 1);
        check("R9 irq", {irq, fiq, prim_valid, 27'd0, prim_idx}, {1'b1, 1'b0, 1'b1, 27'd0, 5'd0});
        wr(O_FST, 32'h1);
        check("R9 fast route", {irq, fiq}, 2'b01);
        wr(O_FST, 0);
        sec_src = '0; idle(7);
        check("R9 cleared", {irq, fiq, prim_valid}, 0);

        // R8 primary lines 1..31, alone and with line 31
        wr(O_POL, 32'hFFFF_FFFF); wr(O_EN, 32'hFFFF_FFFF);
        for (int i = 1; i < NL; i++) begin
            prim_src = '0; prim_src[i] = 1'b1; idle(4);
            check("R8 primary index", prim_idx, i);
            check("R7 primary request", {irq, prim_valid}, 2'b11);
            prim_src[NL-1] = 1'b1; idle(4);
            check("R8 primary lowest", prim_idx, i);
        end
        prim_src = '0; idle(4);
        check("R8 primary idle", prim_valid, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule